// File: doc/BRIEF.md
# SPI Mode Fault Detector

This block watches the slave-select line of an SPI peripheral and compares it with the role that peripheral has been given. If the line contradicts the role, the block records a sticky mode-fault flag. For a slave, that happens when select is released while a byte is still moving. For a master, it happens when select is pulled low. The block also drives the output-enable controls for the serial clock, MOSI and MISO pads. It releases every pad when a master has faulted, so that two drivers never fight over a line.

The select pin arrives asynchronously and passes through a synchronizer before it is evaluated. The fault-enable bit controls only whether a new fault can be recorded. A flag that is already set stays set until software runs the clear sequence:

1. Read the status register while the flag is up.
2. Later, write the control register.

An interrupt request follows the flag when the interrupt-enable bit is set.

Top module: `spi_modf_top`

## Requirements
- R1: With the master role selected (`master_sel`=1) and no fault recorded, `sck_oe` and `mosi_oe` are 1 and `miso_oe` is 0.
- R2: With the slave role selected (`master_sel`=0), `sck_oe` and `mosi_oe` are 0 and `miso_oe` is 1.
- R3: In the slave role with fault detection enabled, a low-to-high change on `ss_n_pin` while `xfer_busy` is 1 sets `mode_fault`. The flag is visible three clock edges after the pin changes. A low select, or a rise with `xfer_busy` at 0, sets nothing.
- R4: In the master role with fault detection enabled, `ss_n_pin` at 0 sets `mode_fault` three clock edges after the pin falls. `xfer_busy` makes no difference.
- R5: While `fault_en` is 0, `mode_fault` is never set from 0 to 1.
- R6: Clearing `fault_en` leaves a recorded `mode_fault` at 1.
- R7: A one-cycle `ctrl_wr` alone does not clear the flag. A `status_rd` pulse while `mode_fault` is 1, followed in a later cycle by `ctrl_wr`, clears the flag at the `ctrl_wr` edge, unless a fault condition is present in that same cycle.
- R8: With the master role selected and `mode_fault` at 1, all three of `sck_oe`, `mosi_oe` and `miso_oe` are 0.
- R9: `irq` equals `mode_fault` AND `irq_en`.
- R10: After reset, `mode_fault` and `irq` are 0 and the synchronized select reads as released (high).
- R11: Once set, `mode_fault` stays 1 after the fault condition goes away, until the clear sequence of R7 completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_sel | input | 1 | 1 = master role, 0 = slave role |
| fault_en | input | 1 | Allows new mode faults to be recorded |
| irq_en | input | 1 | Interrupt enable for the fault flag |
| ss_n_pin | input | 1 | Asynchronous active-low slave-select pin |
| xfer_busy | input | 1 | A byte transfer is in progress |
| status_rd | input | 1 | Strobe: status register read |
| ctrl_wr | input | 1 | Strobe: control register write |
| mode_fault | output | 1 | Sticky mode-fault flag |
| irq | output | 1 | Interrupt request |
| sck_oe | output | 1 | Serial clock pad output enable |
| mosi_oe | output | 1 | MOSI pad output enable |
| miso_oe | output | 1 | MISO pad output enable |

## Verification
A stale synchronizer stage or a wrong edge register moves the appearance of `mode_fault` away from exactly three edges after the pin change. It can also make the flag appear on a slave rise with no transfer running. The sweep samples at that third edge, so such errors show there.

A broken arming register shows up in the clear sequence, one edge after `ctrl_wr`: either a lone write clears the flag, or a proper sequence leaves it set. A wrong direction decode is visible combinationally on the three enables in every role and fault combination the sweep visits.

// File: rtl/spi_modf_pkg.sv
package spi_modf_pkg;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    typedef struct packed {
        logic sck_oe;
        logic mosi_oe;
        logic miso_oe;
    } pad_dir_t;

    localparam int unsigned SYNC_STAGES_DEF = 2;
    localparam logic        SS_IDLE         = 1'b1;

    // Pad direction decode: a faulted master releases everything.
    function automatic pad_dir_t pad_dirs(input role_e role, input logic fault);
        pad_dir_t d;
        if (role == ROLE_MASTER) begin
            d.sck_oe  = !fault;
            d.mosi_oe = !fault;
            d.miso_oe = 1'b0;
        end else begin
            d.sck_oe  = 1'b0;
            d.mosi_oe = 1'b0;
            d.miso_oe = 1'b1;
        end
        return d;
    endfunction

endpackage

// File: rtl/spi_modf_sync.sv
module spi_modf_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out,
    output logic sync_prev
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RESET_VAL;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RESET_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sync_prev <= RESET_VAL;
        else     sync_prev <= chain[STAGES-1];
    end

    assign sync_out = chain[STAGES-1];

    assert_sync_idle_after_reset_R10: assert property (@(posedge clk)
        rst |=> (sync_out == RESET_VAL));

endmodule

// File: rtl/spi_modf_flag.sv
module spi_modf_flag
    import spi_modf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  role_e role,
    input  logic  fault_en,
    input  logic  ss_sync,
    input  logic  ss_prev,
    input  logic  xfer_busy,
    input  logic  status_rd,
    input  logic  ctrl_wr,
    output logic  flag
);
    logic ss_rise;
    logic cond_slave;
    logic cond_master;
    logic set_now;
    logic clr_now;
    logic armed;

    assign ss_rise     = ss_sync && !ss_prev;
    assign cond_slave  = (role == ROLE_SLAVE)  && xfer_busy && ss_rise;
    assign cond_master = (role == ROLE_MASTER) && !ss_sync;
    assign set_now     = fault_en && (cond_slave || cond_master);
    assign clr_now     = armed && ctrl_wr;

    // Arming: status read with the flag up, consumed by any control write.
    always_ff @(posedge clk) begin
        if (rst)          armed <= 1'b0;
        else if (ctrl_wr) armed <= 1'b0;
        else if (status_rd && flag) armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_now) flag <= 1'b1;
        else if (clr_now) flag <= 1'b0;
    end

    assert_no_set_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        (!fault_en && !flag) |=> !flag);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (flag && !ctrl_wr) |=> flag);

    assert_master_low_R4: assert property (@(posedge clk) disable iff (rst)
        (fault_en && role == ROLE_MASTER && !ss_sync) |=> flag);

    assert_slave_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (fault_en && role == ROLE_SLAVE && xfer_busy && ss_sync && !ss_prev) |=> flag);

    assert_lone_write_R7: assert property (@(posedge clk) disable iff (rst)
        (flag && ctrl_wr && !armed) |=> flag);

endmodule

// File: rtl/spi_modf_top.sv
module spi_modf_top
    import spi_modf_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic master_sel,
    input  logic fault_en,
    input  logic irq_en,
    input  logic ss_n_pin,
    input  logic xfer_busy,
    input  logic status_rd,
    input  logic ctrl_wr,
    output logic mode_fault,
    output logic irq,
    output logic sck_oe,
    output logic mosi_oe,
    output logic miso_oe
);
    role_e    role;
    logic     ss_sync;
    logic     ss_prev;
    pad_dir_t dirs;

    assign role = master_sel ? ROLE_MASTER : ROLE_SLAVE;

    spi_modf_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (SS_IDLE)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .async_in  (ss_n_pin),
        .sync_out  (ss_sync),
        .sync_prev (ss_prev)
    );

    spi_modf_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .role      (role),
        .fault_en  (fault_en),
        .ss_sync   (ss_sync),
        .ss_prev   (ss_prev),
        .xfer_busy (xfer_busy),
        .status_rd (status_rd),
        .ctrl_wr   (ctrl_wr),
        .flag      (mode_fault)
    );

    assign dirs    = pad_dirs(role, mode_fault);
    assign sck_oe  = dirs.sck_oe;
    assign mosi_oe = dirs.mosi_oe;
    assign miso_oe = dirs.miso_oe;
    assign irq     = mode_fault && irq_en;

    assert_release_on_fault_R8: assert property (@(posedge clk) disable iff (rst)
        (master_sel && mode_fault) |-> (!sck_oe && !mosi_oe && !miso_oe));

    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
        irq == (mode_fault && irq_en));

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!mode_fault && !irq));

endmodule

// File: tb/tb_spi_modf_top.sv
`timescale 1ns/1ps
module tb_spi_modf_top;
    logic clk = 1'b0;
    logic rst;
    logic master_sel, fault_en, irq_en, ss_n_pin, xfer_busy, status_rd, ctrl_wr;
    logic mode_fault, irq, sck_oe, mosi_oe, miso_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    spi_modf_top dut (
        .clk(clk), .rst(rst), .master_sel(master_sel), .fault_en(fault_en),
        .irq_en(irq_en), .ss_n_pin(ss_n_pin), .xfer_busy(xfer_busy),
        .status_rd(status_rd), .ctrl_wr(ctrl_wr), .mode_fault(mode_fault),
        .irq(irq), .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [2:0] exp_dirs(input logic m, input logic f);
        if (m) return f ? 3'b000 : 3'b110;
        return 3'b001;
    endfunction

    task automatic check_outs(input string req, input logic m, input logic f, input logic ie);
        chk({req, " flag"}, {7'd0, mode_fault}, {7'd0, f});
        chk("R9 irq", {7'd0, irq}, {7'd0, f & ie});
        chk(m ? (f ? "R8 dirs" : "R1 dirs") : "R2 dirs",
            {5'd0, sck_oe, mosi_oe, miso_oe}, {5'd0, exp_dirs(m, f)});
    endtask

    task automatic do_reset;
        rst = 1'b1;
        status_rd = 1'b0; ctrl_wr = 1'b0; ss_n_pin = 1'b1;
        cyc(2);
        rst = 1'b0;
    endtask

    initial begin
        master_sel = 0; fault_en = 0; irq_en = 0; xfer_busy = 0;
        do_reset();
        cyc(1);
        chk("R10 flag", {7'd0, mode_fault}, 8'd0);
        chk("R10 irq", {7'd0, irq}, 8'd0);

        // Sweep role x enable x transfer x irq enable
        for (int c = 0; c < 16; c++) begin
            logic m, en, x, ie, e;
            m = c[0]; en = c[1]; x = c[2]; ie = c[3];
            do_reset();
            master_sel = m; fault_en = en; xfer_busy = x; irq_en = ie;
            cyc(4);
            check_outs("R10 idle", m, 1'b0, ie);
            ss_n_pin = 1'b0;
            cyc(2);
            chk("R4 not early", {7'd0, mode_fault}, 8'd0);
            cyc(1);
            e = en & m;
            check_outs(m ? "R4 low" : "R3 low", m, e, ie);
            ss_n_pin = 1'b1;
            cyc(2);
            chk("R11 hold", {7'd0, mode_fault}, {7'd0, e});
            cyc(1);
            e = e | (en & !m & x);
            check_outs(m ? "R11 sticky" : "R3 rise", m, e, ie);
            cyc(3);
            check_outs("R11 later", m, e, ie);
        end

        // Clear sequence and enable interplay, master role
        do_reset();
        master_sel = 1; fault_en = 1; irq_en = 1; xfer_busy = 0;
        ss_n_pin = 1'b0; cyc(4); ss_n_pin = 1'b1; cyc(4);
        chk("R4 set", {7'd0, mode_fault}, 8'd1);
        fault_en = 0; cyc(2);
        chk("R6 kept", {7'd0, mode_fault}, 8'd1);
        ctrl_wr = 1; cyc(1); ctrl_wr = 0; cyc(1);
        chk("R7 lone write", {7'd0, mode_fault}, 8'd1);
        status_rd = 1; cyc(1); status_rd = 0; cyc(2);
        chk("R7 read only", {7'd0, mode_fault}, 8'd1);
        ctrl_wr = 1; cyc(1); ctrl_wr = 0;
        chk("R7 cleared", {7'd0, mode_fault}, 8'd0);
        check_outs("R7 after", 1'b1, 1'b0, 1'b1);
        ss_n_pin = 1'b0; cyc(5);
        chk("R5 disabled", {7'd0, mode_fault}, 8'd0);
        fault_en = 1; cyc(1);
        chk("R4 enable", {7'd0, mode_fault}, 8'd1);
        ss_n_pin = 1'b1; cyc(4);

        // Slave: rise without transfer, then rise with transfer
        do_reset();
        master_sel = 0; fault_en = 1; irq_en = 0; xfer_busy = 0;
        ss_n_pin = 1'b0; cyc(4); ss_n_pin = 1'b1; cyc(4);
        chk("R3 idle rise", {7'd0, mode_fault}, 8'd0);
        ss_n_pin = 1'b0; cyc(4); xfer_busy = 1; ss_n_pin = 1'b1; cyc(3);
        chk("R3 busy rise", {7'd0, mode_fault}, 8'd1);
        xfer_busy = 0; status_rd = 1; cyc(1); status_rd = 0; ctrl_wr = 1; cyc(1); ctrl_wr = 0;
        chk("R7 slave clear", {7'd0, mode_fault}, 8'd0);

        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule